// File: doc/BRIEF.md
# In-Order Pipeline Stall and Flush Controller

This block holds the control state for a five-stage in-order integer pipeline with the stages fetch, decode, execute, memory and writeback. It keeps one valid bit per stage and the fetch address. Each cycle it decides whether the pipeline advances or freezes, which younger entries are cancelled, and where fetch goes next. Only handshake and busy flags reach it. The datapath, register file, arithmetic units and bus protocol are outside the block.

Only the memory stage may hold the pipeline. It does so while a load or store waits for its bus transfer, or while a multicycle custom instruction asserts its stall flag. The third source is shifts. When the build has no hardware multiplier, a shift or rotate holds the stage while the iterative shifter reports busy. When the build has one, a shift, rotate or multiply holds the stage for a fixed number of cycles, counted by a small state machine. Its states are MS_READY and MS_BUSY, with four transitions:
- READY→READY: no multiplier-class stall is pending.
- READY→BUSY: the first stalled cycle of a multiplier-class operation.
- BUSY→BUSY: the stall continues, and the counter saturates at its last value.
- BUSY→READY: the memory stage releases, or no longer holds a multiplier-class operation.

A redirect selector picks one of four outcomes each cycle: RD_NONE, RD_PREDICT, RD_MISPRED or RD_FLUSH.
- RD_FLUSH: an instruction leaving memory flushes the pipeline.
- RD_MISPRED: an execute-stage branch outcome disagrees with its guess.
- RD_PREDICT: a decode-stage branch with a negative offset is guessed taken.

Top module: `pipe_ctrl`

## Requirements
- R1: While reset is active, all five stage valid bits are 0, `stall_o` is 0 and `fetch_pc_o` equals `RESET_VEC`. The fetch valid bit (bit 0) becomes 1 after the first clock edge following reset release.
- R2: `stall_o` is 1 only when the memory-stage valid bit (bit 3 of `stage_vld_o`) is 1, whatever the other inputs are.
- R3: In a stalled cycle, `stage_en_o` is 5'b10000. Across the following edge, valid bits 3..0 and `fetch_pc_o` keep their values, and the writeback valid bit (bit 4) becomes 0. Nothing moves forward into an empty frozen slot.
- R4: A valid memory-stage load/store (`mem_ldst_i`) stalls in every cycle in which `mem_bus_wait_i` is 1.
- R5: With HW_MUL=0, a memory-stage shift stalls in every cycle in which `mem_shift_busy_i` is 1, and `mem_mul_i` causes no stall.
- R6: With HW_MUL=1, a shift, rotate or multiply (`mem_shift_i` or `mem_mul_i`) occupies the memory stage for exactly MUL_CYC=3 cycles when nothing else stalls, so `stall_o` is 1 for its first two cycles. `mem_shift_busy_i` is then ignored.
- R7: A valid memory-stage multicycle custom instruction (`mem_cust_i`) stalls in every cycle in which `mem_cust_stall_i` is 1.
- R8: When a valid, unstalled memory-stage instruction has `mem_flush_i` set:
  - `cancel_o` is 5'b00111, cancelling the execute, decode and fetch entries.
  - `redir_o` is 1.
  - `fetch_pc_o` equals `mem_flush_pc_i` in the next cycle.
  - The next instruction reaches memory four cycles after the flush.
- R9: `pred_taken_o` is 1 when decode is valid, `dec_branch_i` is 1 and `dec_off_neg_i` is 1 (a negative offset). If nothing of higher priority acts in an unstalled cycle, `cancel_o` is 5'b00001 and the next `fetch_pc_o` is `dec_target_i`. A positive offset is guessed not taken.
- R10: When a valid execute-stage branch has a `ex_taken_i` value that differs from its guess made in decode, and the cycle is unstalled, `cancel_o` is 5'b00011 and the next `fetch_pc_o` is `ex_fix_pc_i`.
- R11: Redirect priority is memory flush first, execute mispredict second, decode prediction last. Cancels and redirects happen only in unstalled cycles.
- R12: `retire_o` is 1 exactly when memory is valid and not stalled, so at most one instruction retires per cycle. That instruction shows as writeback valid in the next cycle.
- R13: In an unstalled cycle without a redirect, the next `fetch_pc_o` is the current value plus 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_ldst_i | input | 1 | Memory-stage instruction is a load or store |
| mem_bus_wait_i | input | 1 | Data bus transfer not finished |
| mem_shift_i | input | 1 | Memory-stage instruction is a shift or rotate |
| mem_shift_busy_i | input | 1 | Iterative shifter still running |
| mem_mul_i | input | 1 | Memory-stage instruction is a multiply |
| mem_cust_i | input | 1 | Memory-stage instruction is a multicycle custom op |
| mem_cust_stall_i | input | 1 | Custom unit requests a hold |
| mem_flush_i | input | 1 | Memory-stage instruction flushes the pipeline |
| mem_flush_pc_i | input | XLEN | Fetch address after a flush |
| ex_branch_i | input | 1 | Execute-stage instruction is a conditional branch |
| ex_taken_i | input | 1 | Resolved branch outcome |
| ex_fix_pc_i | input | XLEN | Correct fetch address after a mispredict |
| dec_branch_i | input | 1 | Decode-stage instruction is a conditional branch |
| dec_off_neg_i | input | 1 | Branch offset is negative |
| dec_target_i | input | XLEN | Branch target computed in decode |
| stage_vld_o | output | 5 | Valid bits, bit 0 fetch up to bit 4 writeback |
| stage_en_o | output | 5 | Stage register load enables, same order |
| cancel_o | output | 5 | Entries cancelled this cycle, same order |
| stall_o | output | 1 | Memory-stage hold |
| retire_o | output | 1 | Instruction leaves memory this cycle |
| redir_o | output | 1 | Fetch address is replaced at the next edge |
| pred_taken_o | output | 1 | Static guess for the decode-stage branch |
| fetch_pc_o | output | XLEN | Address being fetched |

## Verification
Two instances run side by side on the same inputs: one built with the hardware multiplier and one without. Their stall behaviour on the same shift and multiply flags therefore tells the two shifter variants apart. Memory-stage instruction flags are held while the multiplier build stalls, so its three-cycle occupancy shows up. Bus-wait, shifter-busy and custom-stall flags change every cycle, which separates level-driven holds from the counted hold. Random overlaps of flush, mispredict and backward-branch requests show whether the redirect priority and cancel masks are right. Stalls landing on those requests show that nothing is cancelled while the pipeline is frozen.

// File: rtl/pipe_ctrl_pkg.sv
package pipe_ctrl_pkg;
    localparam int NSTG = 5;
    localparam int SF   = 0;
    localparam int SD   = 1;
    localparam int SX   = 2;
    localparam int SM   = 3;
    localparam int SW   = 4;
    localparam int NKILL = SM;   // fetch, decode, execute may be cancelled

    typedef enum logic [0:0] {
        MS_READY,
        MS_BUSY
    } mstate_e;

    typedef enum logic [1:0] {
        RD_NONE,
        RD_PREDICT,
        RD_MISPRED,
        RD_FLUSH
    } redir_e;
endpackage

// File: rtl/pipe_mstall.sv
// Memory-stage hold generation; the fixed-latency multiplier hold is sequenced
// by a two-state machine with a saturating cycle counter.
module pipe_mstall #(
    parameter int HW_MUL  = 1,
    parameter int MUL_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic m_vld,
    input  logic is_ldst,
    input  logic bus_wait,
    input  logic is_shift,
    input  logic shift_busy,
    input  logic is_mul,
    input  logic is_cust,
    input  logic cust_stall,
    output logic stall
);
    import pipe_ctrl_pkg::*;

    localparam int CW = $clog2(MUL_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(MUL_CYC - 1);

    mstate_e         st_q, st_d;
    logic [CW-1:0]   cnt_q, cnt_d;
    logic [CW-1:0]   elapsed;
    logic            mul_class;
    logic            iter_hold;
    logic            mul_hold;

    // variant selection: which unit carries shifts
    assign mul_class = (HW_MUL != 0) & (is_shift | is_mul);
    assign iter_hold = (HW_MUL == 0) & is_shift & shift_busy;

    always_comb begin
        elapsed  = (st_q == MS_BUSY) ? cnt_q : '0;
        mul_hold = m_vld & mul_class & (elapsed < LAST);
        stall    = mul_hold
                 | (m_vld & ((is_ldst & bus_wait)
                           | (is_cust & cust_stall)
                           | iter_hold));
    end

    // next-state and output decisions
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            MS_READY: begin
                if (m_vld && mul_class && stall) begin
                    st_d  = MS_BUSY;
                    cnt_d = CW'(1);
                end else begin
                    cnt_d = '0;
                end
            end
            MS_BUSY: begin
                if (m_vld && mul_class && stall) begin
                    cnt_d = (cnt_q == LAST) ? cnt_q : cnt_q + CW'(1);
                end else begin
                    st_d  = MS_READY;
                    cnt_d = '0;
                end
            end
            default: begin
                st_d  = MS_READY;
                cnt_d = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= MS_READY;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/pipe_steer.sv
// Redirect arbitration, static branch guess and fetch address register.
module pipe_steer #(
    parameter int              XLEN      = 32,
    parameter logic [XLEN-1:0] RESET_VEC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stall,
    input  logic            m_vld,
    input  logic            m_flush,
    input  logic [XLEN-1:0] flush_pc,
    input  logic            x_vld,
    input  logic            x_guess,
    input  logic            x_branch,
    input  logic            x_taken,
    input  logic [XLEN-1:0] x_fix_pc,
    input  logic            d_vld,
    input  logic            d_branch,
    input  logic            d_neg,
    input  logic [XLEN-1:0] d_target,
    output logic            guess_taken,
    output logic [2:0]      kill,
    output logic            redir,
    output logic [XLEN-1:0] fetch_pc
);
    import pipe_ctrl_pkg::*;

    redir_e          sel;
    logic [XLEN-1:0] tgt;
    logic [XLEN-1:0] pc_q;
    logic            wrong;

    assign guess_taken = d_vld & d_branch & d_neg;
    assign wrong       = x_vld & x_branch & (x_taken != x_guess);

    always_comb begin
        sel = RD_NONE;
        if (!stall) begin
            if (m_vld && m_flush)  sel = RD_FLUSH;
            else if (wrong)        sel = RD_MISPRED;
            else if (guess_taken)  sel = RD_PREDICT;
        end
    end

    always_comb begin
        kill  = 3'b000;
        tgt   = pc_q + XLEN'(4);
        redir = 1'b0;
        unique case (sel)
            RD_NONE: begin
                kill = 3'b000;
            end
            RD_PREDICT: begin
                kill  = 3'b001;
                tgt   = d_target;
                redir = 1'b1;
            end
            RD_MISPRED: begin
                kill  = 3'b011;
                tgt   = x_fix_pc;
                redir = 1'b1;
            end
            RD_FLUSH: begin
                kill  = 3'b111;
                tgt   = flush_pc;
                redir = 1'b1;
            end
            default: begin
                kill = 3'b000;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pc_q <= RESET_VEC;
        else if (!stall) pc_q <= tgt;
    end

    assign fetch_pc = pc_q;
endmodule

// File: rtl/pipe_vchain.sv
// Stage valid bits, load enables and the guess bit carried into execute.
module pipe_vchain (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stall,
    input  logic [2:0] kill,
    input  logic       d_guess,
    output logic [4:0] vld,
    output logic [4:0] en,
    output logic       x_guess,
    output logic       retire
);
    import pipe_ctrl_pkg::*;

    logic [NSTG-1:0] vld_q;
    logic            guess_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q   <= '0;
            guess_q <= 1'b0;
        end else begin
            if (!stall) begin
                vld_q[SF] <= 1'b1;
                for (int s = SD; s <= SM; s++) begin
                    vld_q[s] <= vld_q[s-1] & ~kill[s-1];
                end
                guess_q <= d_guess;
            end
            vld_q[SW] <= vld_q[SM] & ~stall;
        end
    end

    for (genvar g = 0; g < NSTG; g++) begin : g_en
        if (g == SW) begin : g_wb
            assign en[g] = 1'b1;
        end else begin : g_fr
            assign en[g] = ~stall;
        end
    end

    assign vld     = vld_q;
    assign x_guess = guess_q;
    assign retire  = vld_q[SM] & ~stall;
endmodule

// File: rtl/pipe_ctrl.sv
module pipe_ctrl #(
    parameter int              XLEN      = 32,
    parameter logic [XLEN-1:0] RESET_VEC = XLEN'(32'h0000_0100),
    parameter int              HW_MUL    = 1,
    parameter int              MUL_CYC   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mem_ldst_i,
    input  logic            mem_bus_wait_i,
    input  logic            mem_shift_i,
    input  logic            mem_shift_busy_i,
    input  logic            mem_mul_i,
    input  logic            mem_cust_i,
    input  logic            mem_cust_stall_i,
    input  logic            mem_flush_i,
    input  logic [XLEN-1:0] mem_flush_pc_i,
    input  logic            ex_branch_i,
    input  logic            ex_taken_i,
    input  logic [XLEN-1:0] ex_fix_pc_i,
    input  logic            dec_branch_i,
    input  logic            dec_off_neg_i,
    input  logic [XLEN-1:0] dec_target_i,
    output logic [4:0]      stage_vld_o,
    output logic [4:0]      stage_en_o,
    output logic [4:0]      cancel_o,
    output logic            stall_o,
    output logic            retire_o,
    output logic            redir_o,
    output logic            pred_taken_o,
    output logic [XLEN-1:0] fetch_pc_o
);
    import pipe_ctrl_pkg::*;

    logic [4:0] vld;
    logic [2:0] kill;
    logic       stall;
    logic       x_guess;
    logic       guess;

    pipe_mstall #(.HW_MUL(HW_MUL), .MUL_CYC(MUL_CYC)) u_mstall (
        .clk        (clk),
        .rst_n      (rst_n),
        .m_vld      (vld[SM]),
        .is_ldst    (mem_ldst_i),
        .bus_wait   (mem_bus_wait_i),
        .is_shift   (mem_shift_i),
        .shift_busy (mem_shift_busy_i),
        .is_mul     (mem_mul_i),
        .is_cust    (mem_cust_i),
        .cust_stall (mem_cust_stall_i),
        .stall      (stall)
    );

    pipe_steer #(.XLEN(XLEN), .RESET_VEC(RESET_VEC)) u_steer (
        .clk         (clk),
        .rst_n       (rst_n),
        .stall       (stall),
        .m_vld       (vld[SM]),
        .m_flush     (mem_flush_i),
        .flush_pc    (mem_flush_pc_i),
        .x_vld       (vld[SX]),
        .x_guess     (x_guess),
        .x_branch    (ex_branch_i),
        .x_taken     (ex_taken_i),
        .x_fix_pc    (ex_fix_pc_i),
        .d_vld       (vld[SD]),
        .d_branch    (dec_branch_i),
        .d_neg       (dec_off_neg_i),
        .d_target    (dec_target_i),
        .guess_taken (guess),
        .kill        (kill),
        .redir       (redir_o),
        .fetch_pc    (fetch_pc_o)
    );

    pipe_vchain u_vchain (
        .clk     (clk),
        .rst_n   (rst_n),
        .stall   (stall),
        .kill    (kill),
        .d_guess (guess),
        .vld     (vld),
        .en      (stage_en_o),
        .x_guess (x_guess),
        .retire  (retire_o)
    );

    assign stage_vld_o  = vld;
    assign cancel_o     = {2'b00, kill};
    assign stall_o      = stall;
    assign pred_taken_o = guess;
endmodule

// File: rtl/pipe_ctrl_chk.sv
module pipe_ctrl_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mem_flush_i,
    input logic [XLEN-1:0] mem_flush_pc_i,
    input logic [XLEN-1:0] dec_target_i,
    input logic [4:0]      stage_vld_o,
    input logic [4:0]      cancel_o,
    input logic            stall_o,
    input logic            retire_o,
    input logic            redir_o,
    input logic            pred_taken_o,
    input logic [XLEN-1:0] fetch_pc_o
);
    assert_only_mem_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !stage_vld_o[3] |-> !stall_o);

    assert_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> ($stable(fetch_pc_o) && stage_vld_o[3:0] == $past(stage_vld_o[3:0])));

    assert_wb_bubble_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> !stage_vld_o[4]);

    assert_cancel_free_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cancel_o != 5'b0) |-> !stall_o);

    assert_flush_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_o[2] |-> (cancel_o[1:0] == 2'b11));

    assert_flush_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_flush_i && stage_vld_o[3] && !stall_o) |=> fetch_pc_o == $past(mem_flush_pc_i));

    assert_guess_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_taken_o && cancel_o == 5'b00001) |=> fetch_pc_o == $past(dec_target_i));

    assert_retire_R12: assert property (@(posedge clk) disable iff (!rst_n)
        retire_o |=> stage_vld_o[4]);

    assert_seq_pc_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_o && !redir_o) |=> fetch_pc_o == $past(fetch_pc_o) + XLEN'(4));
endmodule

bind pipe_ctrl pipe_ctrl_chk #(.XLEN(XLEN)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .mem_flush_i    (mem_flush_i),
    .mem_flush_pc_i (mem_flush_pc_i),
    .dec_target_i   (dec_target_i),
    .stage_vld_o    (stage_vld_o),
    .cancel_o       (cancel_o),
    .stall_o        (stall_o),
    .retire_o       (retire_o),
    .redir_o        (redir_o),
    .pred_taken_o   (pred_taken_o),
    .fetch_pc_o     (fetch_pc_o)
);

// File: tb/pipe_ctrl_tb_top.sv
module pipe_ctrl_tb_top;
    localparam int          XLEN = 32;
    localparam logic [31:0] RVEC = 32'h0000_0100;
    localparam int          NCYC = 4000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic ldst, bwait, shf, shbusy, mul, cust, cstall, mflush;
    logic xbr, xtk, dbr, dneg;
    logic [31:0] fpc, xpc, dtgt;

    logic [4:0]  o_vld [2];
    logic [4:0]  o_en  [2];
    logic [4:0]  o_can [2];
    logic        o_stall [2];
    logic        o_ret [2];
    logic        o_red [2];
    logic        o_pred [2];
    logic [31:0] o_pc [2];

    pipe_ctrl #(.XLEN(XLEN), .RESET_VEC(RVEC), .HW_MUL(1), .MUL_CYC(3)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .mem_ldst_i(ldst), .mem_bus_wait_i(bwait), .mem_shift_i(shf),
        .mem_shift_busy_i(shbusy), .mem_mul_i(mul), .mem_cust_i(cust),
        .mem_cust_stall_i(cstall), .mem_flush_i(mflush), .mem_flush_pc_i(fpc),
        .ex_branch_i(xbr), .ex_taken_i(xtk), .ex_fix_pc_i(xpc),
        .dec_branch_i(dbr), .dec_off_neg_i(dneg), .dec_target_i(dtgt),
        .stage_vld_o(o_vld[0]), .stage_en_o(o_en[0]), .cancel_o(o_can[0]),
        .stall_o(o_stall[0]), .retire_o(o_ret[0]), .redir_o(o_red[0]),
        .pred_taken_o(o_pred[0]), .fetch_pc_o(o_pc[0])
    );

    pipe_ctrl #(.XLEN(XLEN), .RESET_VEC(RVEC), .HW_MUL(0), .MUL_CYC(3)) dut_nomul_i (
        .clk(clk), .rst_n(rst_n),
        .mem_ldst_i(ldst), .mem_bus_wait_i(bwait), .mem_shift_i(shf),
        .mem_shift_busy_i(shbusy), .mem_mul_i(mul), .mem_cust_i(cust),
        .mem_cust_stall_i(cstall), .mem_flush_i(mflush), .mem_flush_pc_i(fpc),
        .ex_branch_i(xbr), .ex_taken_i(xtk), .ex_fix_pc_i(xpc),
        .dec_branch_i(dbr), .dec_off_neg_i(dneg), .dec_target_i(dtgt),
        .stage_vld_o(o_vld[1]), .stage_en_o(o_en[1]), .cancel_o(o_can[1]),
        .stall_o(o_stall[1]), .retire_o(o_ret[1]), .redir_o(o_red[1]),
        .pred_taken_o(o_pred[1]), .fetch_pc_o(o_pc[1])
    );

    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference state per instance: queue-free behavioural occupancy model
    bit [4:0]  m_v [2];
    bit        m_g [2];
    bit [31:0] m_pc [2];
    int        m_age [2];
    bit        e_stall [2];

    task automatic chk(input string req, input int k, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s inst=%0d t=%0t actual=%h expected=%h", req, k, $time, act, exp);
        end
    endtask

    task automatic model_step(input int k);
        bit        hw, vm, stl, guess, wrong, rd;
        bit [2:0]  kl;
        bit [31:0] tgt;
        int        occ;
        bit [4:0]  nv;
        hw  = (k == 0);
        vm  = m_v[k][3];
        occ = m_age[k];
        stl = 0;
        if (vm && ldst && bwait) stl = 1;        // R4
        if (vm && cust && cstall) stl = 1;       // R7
        if (vm && !hw && shf && shbusy) stl = 1; // R5
        if (vm && hw && (shf || mul) && occ < 2) stl = 1; // R6: third cycle releases
        guess = m_v[k][1] && dbr && dneg;
        wrong = m_v[k][2] && xbr && (xtk != m_g[k]);
        kl = 3'b000; tgt = m_pc[k] + 32'd4;
        if (!stl) begin
            if (vm && mflush)  begin kl = 3'b111; tgt = fpc;  end
            else if (wrong)    begin kl = 3'b011; tgt = xpc;  end
            else if (guess)    begin kl = 3'b001; tgt = dtgt; end
        end
        rd = (kl != 3'b000);
        e_stall[k] = stl;
        chk("R2 R4 R5 R6 R7 stall", k, 32'(o_stall[k]), 32'(stl));
        chk("R1 R3 valid bits", k, 32'(o_vld[k]), 32'(m_v[k]));
        chk("R3 enables", k, 32'(o_en[k]), stl ? 32'h10 : 32'h1f);
        chk("R8 R9 R10 R11 cancel mask", k, 32'(o_can[k]), 32'(kl));
        chk("R8 R9 R10 R11 redirect", k, 32'(o_red[k]), 32'(rd));
        chk("R9 guess", k, 32'(o_pred[k]), 32'(guess));
        chk("R12 retire", k, 32'(o_ret[k]), 32'(vm && !stl));
        chk("R1 R13 fetch address", k, o_pc[k], m_pc[k]);
        // advance
        nv = m_v[k];
        nv[4] = vm && !stl;
        if (!stl) begin
            nv[0] = 1;
            nv[1] = m_v[k][0] && !kl[0];
            nv[2] = m_v[k][1] && !kl[1];
            nv[3] = m_v[k][2] && !kl[2];
            m_g[k]  = guess;
            m_pc[k] = tgt;
        end
        if (vm && hw && (shf || mul) && stl) m_age[k] = (occ + 1 > 2) ? 2 : occ + 1;
        else m_age[k] = 0;
        m_v[k] = nv;
    endtask

    task automatic drive(input bit keep_m);
        if (!keep_m) begin
            ldst   = ($urandom_range(0, 2) == 0);
            shf    = ($urandom_range(0, 4) == 0);
            mul    = ($urandom_range(0, 5) == 0);
            cust   = ($urandom_range(0, 5) == 0);
            mflush = ($urandom_range(0, 12) == 0);
            fpc    = {$urandom_range(0, 32'hffff), 2'b00};
        end
        bwait  = $urandom_range(0, 1);
        shbusy = $urandom_range(0, 1);
        cstall = ($urandom_range(0, 2) == 0);
        xbr    = ($urandom_range(0, 2) == 0);
        xtk    = $urandom_range(0, 1);
        xpc    = {$urandom_range(0, 32'hffff), 2'b00};
        dbr    = ($urandom_range(0, 2) == 0);
        dneg   = $urandom_range(0, 1);
        dtgt   = {$urandom_range(0, 32'hffff), 2'b00};
    endtask

    initial begin
        ldst = 0; bwait = 0; shf = 0; shbusy = 0; mul = 0; cust = 0; cstall = 0;
        mflush = 0; xbr = 0; xtk = 0; dbr = 0; dneg = 0;
        fpc = '0; xpc = '0; dtgt = '0;
        repeat (3) @(negedge clk);
        // R1: reset state, inputs driven to provoke activity
        ldst = 1; bwait = 1; dbr = 1; dneg = 1; mflush = 1;
        #1;
        for (int k = 0; k < 2; k++) begin
            chk("R1 reset valid", k, 32'(o_vld[k]), 32'h0);
            chk("R1 reset stall", k, 32'(o_stall[k]), 32'h0);
            chk("R1 reset pc", k, o_pc[k], RVEC);
            chk("R1 reset retire", k, 32'(o_ret[k]), 32'h0);
            m_v[k] = '0; m_g[k] = 0; m_pc[k] = RVEC; m_age[k] = 0; e_stall[k] = 0;
        end
        @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < NCYC; c++) begin
            drive(e_stall[0]);
            #2;
            for (int k = 0; k < 2; k++) model_step(k);
            @(posedge clk);
            @(negedge clk);
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule